// File: doc/BRIEF.md
# Memory Micro-op Issue Unit

This block sits between a thread's memory micro-op queues and the data-cache request port. It holds three small age-ordered queues: one for stores, one for loads and one for prefetches. In each issue round it hands at most a fixed number of operations (the quantum) to the cache, one request per cycle. The three queues share that quantum. Stores leave strictly from the head of their queue and only once committed. Loads may leave out of order as soon as their operands are ready. A prefetch whose cache block was prefetched recently is discarded without touching the cache.

Control is a four-state machine. `S_IDLE` reloads the quantum and moves to `S_STORE` once the cache can accept a request. `S_STORE` issues the head store for as long as that store is committed and the cache accepts. `S_LOAD` issues the oldest ready load under the same condition. `S_PREF` either drops a redundant head prefetch, which costs no quantum, or issues it. Every issue decrements the quantum. When the quantum reaches zero the machine returns to `S_IDLE`. A state that finds nothing it may issue passes on: `S_STORE` goes to `S_LOAD`, `S_LOAD` goes to `S_PREF`, and `S_PREF` goes to `S_IDLE`.

Each request carries the address, a 2-bit access kind and the issue-cycle stamp taken from the cycle input. Operand readiness for loads and prefetches arrives as an address broadcast. Store commit arrives as a pulse that marks the oldest uncommitted store.

Top module: `mem_uop_issue`

## Requirements
- R1: After reset no request or drop is presented and none of the three queues reports full.
- R2: Stores issue only from the head of the store queue and in push order. An uncommitted head store blocks every store behind it, even committed ones. A `st_commit` pulse marks the oldest uncommitted store as committed.
- R3: No request is presented in a cycle where `cache_rdy` is low. Operations that were held back issue once `cache_rdy` returns high.
- R4: A load that is not ready is skipped, and younger ready loads issue ahead of it. A `wake_valid` broadcast marks every queued load or prefetch whose address equals `wake_addr` as ready.
- R5: A ready head prefetch whose block address (address divided by `BLOCK_BYTES`) is in the history is removed and reported on `pf_drop`, with no cache request and no quantum used. Issue then continues in the same state.
- R6: Every issued prefetch writes its block address into a 4-entry history. When the history is full, the oldest entry is overwritten.
- R7: Within a round, at most `QUANTUM` operations issue, one per cycle. Stores are served first, then loads, then prefetches. An exhausted quantum returns the machine to `S_IDLE` for one cycle before the next round.
- R8: `req_cycle` equals `cycle_in` in the cycle the request is presented.
- R9: Each queue holds `DEPTH` entries and raises its full flag when `DEPTH` entries are held. A push into a full queue is discarded.
- R10: `req_kind` encodes the access: 2'b01 for a load, 2'b10 for a store, 2'b11 for a prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_push | input | 1 | Push a store |
| st_push_addr | input | AW | Store address |
| st_push_cmt | input | 1 | Store is already committed at push |
| st_commit | input | 1 | Mark the oldest uncommitted store committed |
| ld_push | input | 1 | Push a load |
| ld_push_addr | input | AW | Load address |
| ld_push_rdy | input | 1 | Load operands ready at push |
| pf_push | input | 1 | Push a prefetch |
| pf_push_addr | input | AW | Prefetch address |
| pf_push_rdy | input | 1 | Prefetch operands ready at push |
| wake_valid | input | 1 | Readiness broadcast valid |
| wake_addr | input | AW | Address whose loads and prefetches become ready |
| cache_rdy | input | 1 | Cache can accept a request this cycle |
| cycle_in | input | CYW | Current cycle count |
| req_valid | output | 1 | Cache request presented |
| req_kind | output | 2 | Access kind (R10 encoding) |
| req_addr | output | AW | Request address |
| req_cycle | output | CYW | Issue-cycle stamp |
| pf_drop | output | 1 | Redundant prefetch removed this cycle |
| pf_drop_addr | output | AW | Address of the dropped prefetch |
| st_full | output | 1 | Store queue full |
| ld_full | output | 1 | Load queue full |
| pf_full | output | 1 | Prefetch queue full |

## Verification
Pushes, commit pulses and wake broadcasts take effect at the clock edge that samples them. A request or drop is decoded combinationally from the state held after that edge, so it appears in the same cycle the machine reaches the serving state. The bench drives inputs just after a rising edge and records requests and drops at the falling edge, together with the cycle stamp in force then. Checks on ordering and round gaps compare those recorded stamps: four stores followed by a load and a prefetch show a gap of two between the third and fourth store, where the `S_IDLE` cycle sits. A dropped prefetch that costs no quantum places the next prefetch four cycles after the last store; if it did cost quantum the gap would be seven. Ordering tests hold `cache_rdy` low for several cycles first, which parks the machine in `S_IDLE` and gives every round a known start.

// File: rtl/mem_uop_pkg.sv
package mem_uop_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_PREF  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_STORE,
        S_LOAD,
        S_PREF
    } issue_state_e;

endpackage

// File: rtl/mem_uop_queue.sv
// Age-ordered collapsing queue: entry 0 is the oldest.
// Any entry can be removed; younger entries shift down by one.
module mem_uop_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [AW-1:0]             push_addr_i,
    input  logic                      push_flag_i,
    input  logic                      pop_i,
    input  logic [IW-1:0]             pop_idx_i,
    input  logic [DEPTH-1:0]          set_i,
    output logic [DEPTH-1:0]          valid_o,
    output logic [DEPTH-1:0][AW-1:0]  addr_o,
    output logic [DEPTH-1:0]          flag_o,
    output logic                      full_o
);

    logic [DEPTH-1:0][AW-1:0] addr_q, addr_n;
    logic [DEPTH-1:0]         flag_q, flag_n;
    logic [CW-1:0]            cnt_q, cnt_n, cnt_base;
    logic                     push_ok;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign addr_o  = addr_q;
    assign flag_o  = flag_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_o[i] = (CW'(i) < cnt_q);
        end
    end

    always_comb begin
        cnt_base = cnt_q - CW'(pop_i);
        for (int i = 0; i < DEPTH; i++) begin
            if (pop_i && i >= int'(pop_idx_i)) begin
                if (i + 1 < DEPTH) begin
                    addr_n[i] = addr_q[(i + 1) % DEPTH];
                    flag_n[i] = flag_q[(i + 1) % DEPTH] | set_i[(i + 1) % DEPTH];
                end else begin
                    addr_n[i] = '0;
                    flag_n[i] = 1'b0;
                end
            end else begin
                addr_n[i] = addr_q[i];
                flag_n[i] = flag_q[i] | set_i[i];
            end
        end
        if (push_ok) begin
            addr_n[cnt_base[IW-1:0]] = push_addr_i;
            flag_n[cnt_base[IW-1:0]] = push_flag_i;
        end
        cnt_n = cnt_base + CW'(push_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            flag_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_n;
            flag_q <= flag_n;
            cnt_q  <= cnt_n;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R9

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH))); // R9

endmodule

// File: rtl/mem_uop_pf_hist.sv
// Recent-prefetch block history: small FIFO, oldest entry overwritten.
module mem_uop_pf_hist #(
    parameter int ENTRIES = 4,
    parameter int BW      = 26,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] query_i,
    output logic          hit_o,
    input  logic          wr_en_i,
    input  logic [BW-1:0] wr_blk_i
);

    logic [ENTRIES-1:0][BW-1:0] blk_q;
    logic [ENTRIES-1:0]         vld_q;
    logic [PW-1:0]              wptr_q;

    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld_q[i] && blk_q[i] == query_i) hit_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            vld_q  <= '0;
            wptr_q <= '0;
        end else if (wr_en_i) begin
            blk_q[wptr_q] <= wr_blk_i;
            vld_q[wptr_q] <= 1'b1;
            wptr_q        <= (wptr_q == PW'(ENTRIES - 1)) ? '0 : wptr_q + PW'(1);
        end
    end

    AST_HIST_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (vld_q[$past(wptr_q)] && blk_q[$past(wptr_q)] == $past(wr_blk_i))); // R6

endmodule

// File: rtl/mem_uop_issue.sv
module mem_uop_issue
    import mem_uop_pkg::*;
#(
    parameter int AW          = 32,
    parameter int CYW         = 32,
    parameter int DEPTH       = 8,
    parameter int QUANTUM     = 3,
    parameter int HIST        = 4,
    parameter int BLOCK_BYTES = 64,
    localparam int IW         = $clog2(DEPTH),
    localparam int QW         = $clog2(QUANTUM + 1),
    localparam int BSH        = $clog2(BLOCK_BYTES),
    localparam int BW         = AW - BSH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_push,
    input  logic [AW-1:0]  st_push_addr,
    input  logic           st_push_cmt,
    input  logic           st_commit,
    input  logic           ld_push,
    input  logic [AW-1:0]  ld_push_addr,
    input  logic           ld_push_rdy,
    input  logic           pf_push,
    input  logic [AW-1:0]  pf_push_addr,
    input  logic           pf_push_rdy,
    input  logic           wake_valid,
    input  logic [AW-1:0]  wake_addr,
    input  logic           cache_rdy,
    input  logic [CYW-1:0] cycle_in,
    output logic           req_valid,
    output logic [1:0]     req_kind,
    output logic [AW-1:0]  req_addr,
    output logic [CYW-1:0] req_cycle,
    output logic           pf_drop,
    output logic [AW-1:0]  pf_drop_addr,
    output logic           st_full,
    output logic           ld_full,
    output logic           pf_full
);

    issue_state_e state_q, state_n;
    logic [QW-1:0] quant_q;
    logic          issue;

    logic [DEPTH-1:0]         st_vld, st_flg, st_set;
    logic [DEPTH-1:0][AW-1:0] st_adr;
    logic [DEPTH-1:0]         ld_vld, ld_flg, ld_set;
    logic [DEPTH-1:0][AW-1:0] ld_adr;
    logic [DEPTH-1:0]         pf_vld, pf_flg, pf_set;
    logic [DEPTH-1:0][AW-1:0] pf_adr;

    logic          st_pop, ld_pop, pf_pop;
    logic [IW-1:0] ld_idx;
    logic          ld_any;
    logic          hist_hit, hist_wr;
    logic [BW-1:0] pf_blk;

    // Store commit: mark the oldest valid uncommitted store.
    always_comb begin
        logic found;
        found  = 1'b0;
        st_set = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_commit && !found && st_vld[i] && !st_flg[i]) begin
                st_set[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // Readiness broadcast by address for loads and prefetches.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ld_set[i] = wake_valid && ld_vld[i] && ld_adr[i] == wake_addr;
            pf_set[i] = wake_valid && pf_vld[i] && pf_adr[i] == wake_addr;
        end
    end

    // Oldest ready load.
    always_comb begin
        ld_any = 1'b0;
        ld_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ld_vld[i] && ld_flg[i]) begin
                ld_any = 1'b1;
                ld_idx = IW'(i);
            end
        end
    end

    assign pf_blk = pf_adr[0][AW-1:BSH];

    mem_uop_queue #(.DEPTH(DEPTH), .AW(AW)) u_st_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(st_push), .push_addr_i(st_push_addr), .push_flag_i(st_push_cmt),
        .pop_i(st_pop), .pop_idx_i('0), .set_i(st_set),
        .valid_o(st_vld), .addr_o(st_adr), .flag_o(st_flg), .full_o(st_full)
    );

    mem_uop_queue #(.DEPTH(DEPTH), .AW(AW)) u_ld_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(ld_push), .push_addr_i(ld_push_addr), .push_flag_i(ld_push_rdy),
        .pop_i(ld_pop), .pop_idx_i(ld_idx), .set_i(ld_set),
        .valid_o(ld_vld), .addr_o(ld_adr), .flag_o(ld_flg), .full_o(ld_full)
    );

    mem_uop_queue #(.DEPTH(DEPTH), .AW(AW)) u_pf_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(pf_push), .push_addr_i(pf_push_addr), .push_flag_i(pf_push_rdy),
        .pop_i(pf_pop), .pop_idx_i('0), .set_i(pf_set),
        .valid_o(pf_vld), .addr_o(pf_adr), .flag_o(pf_flg), .full_o(pf_full)
    );

    mem_uop_pf_hist #(.ENTRIES(HIST), .BW(BW)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .query_i(pf_blk), .hit_o(hist_hit),
        .wr_en_i(hist_wr), .wr_blk_i(pf_blk)
    );

    // State and quantum registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            quant_q <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == S_IDLE) quant_q <= QW'(QUANTUM);
            else if (issue)        quant_q <= quant_q - QW'(1);
        end
    end

    // Next state and outputs.
    always_comb begin
        state_n      = state_q;
        issue        = 1'b0;
        req_kind     = KIND_NONE;
        req_addr     = '0;
        st_pop       = 1'b0;
        ld_pop       = 1'b0;
        pf_pop       = 1'b0;
        hist_wr      = 1'b0;
        pf_drop      = 1'b0;
        pf_drop_addr = '0;
        unique case (state_q)
            S_IDLE: begin
                if (cache_rdy) state_n = S_STORE;
            end
            S_STORE: begin
                if (st_vld[0] && st_flg[0] && cache_rdy) begin
                    issue    = 1'b1;
                    st_pop   = 1'b1;
                    req_kind = KIND_STORE;
                    req_addr = st_adr[0];
                    if (quant_q == QW'(1)) state_n = S_IDLE;
                end else begin
                    state_n = S_LOAD;
                end
            end
            S_LOAD: begin
                if (ld_any && cache_rdy) begin
                    issue    = 1'b1;
                    ld_pop   = 1'b1;
                    req_kind = KIND_LOAD;
                    req_addr = ld_adr[ld_idx];
                    if (quant_q == QW'(1)) state_n = S_IDLE;
                end else begin
                    state_n = S_PREF;
                end
            end
            S_PREF: begin
                if (pf_vld[0] && pf_flg[0] && hist_hit) begin
                    pf_pop       = 1'b1;
                    pf_drop      = 1'b1;
                    pf_drop_addr = pf_adr[0];
                end else if (pf_vld[0] && pf_flg[0] && cache_rdy) begin
                    issue    = 1'b1;
                    pf_pop   = 1'b1;
                    hist_wr  = 1'b1;
                    req_kind = KIND_PREF;
                    req_addr = pf_adr[0];
                    if (quant_q == QW'(1)) state_n = S_IDLE;
                end else begin
                    state_n = S_IDLE;
                end
            end
        endcase
    end

    assign req_valid = issue;
    assign req_cycle = cycle_in;

    // Checker state: requests issued since the round began.
    logic [QW-1:0] round_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                round_cnt <= '0;
        else if (state_q == S_IDLE) round_cnt <= '0;
        else if (req_valid)        round_cnt <= round_cnt + QW'(1);
    end

    AST_REQ_NEEDS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> cache_rdy); // R3

    AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pf_drop |-> !req_valid); // R5

    AST_QUANTUM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (round_cnt < QW'(QUANTUM))); // R7

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind != KIND_NONE)); // R10

    AST_STORE_ONLY_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_STORE) |-> st_flg[0]); // R2

endmodule

// File: tb/test_mem_uop_issue.sv
module test_mem_uop_issue;

    localparam int AW  = 32;
    localparam int CYW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           st_push = 0, st_push_cmt = 0, st_commit = 0;
    logic [AW-1:0]  st_push_addr = '0;
    logic           ld_push = 0, ld_push_rdy = 0;
    logic [AW-1:0]  ld_push_addr = '0;
    logic           pf_push = 0, pf_push_rdy = 0;
    logic [AW-1:0]  pf_push_addr = '0;
    logic           wake_valid = 0;
    logic [AW-1:0]  wake_addr = '0;
    logic           cache_rdy = 0;
    logic [CYW-1:0] cycle_in = '0;
    logic           req_valid, pf_drop, st_full, ld_full, pf_full;
    logic [1:0]     req_kind;
    logic [AW-1:0]  req_addr, pf_drop_addr;
    logic [CYW-1:0] req_cycle;

    mem_uop_issue i_mem_uop_issue (
        .clk(clk), .rst_n(rst_n),
        .st_push(st_push), .st_push_addr(st_push_addr), .st_push_cmt(st_push_cmt),
        .st_commit(st_commit),
        .ld_push(ld_push), .ld_push_addr(ld_push_addr), .ld_push_rdy(ld_push_rdy),
        .pf_push(pf_push), .pf_push_addr(pf_push_addr), .pf_push_rdy(pf_push_rdy),
        .wake_valid(wake_valid), .wake_addr(wake_addr),
        .cache_rdy(cache_rdy), .cycle_in(cycle_in),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_cycle(req_cycle), .pf_drop(pf_drop), .pf_drop_addr(pf_drop_addr),
        .st_full(st_full), .ld_full(ld_full), .pf_full(pf_full)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycle_in <= cycle_in + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0]     lg_kind [64];
    logic [AW-1:0]  lg_addr [64];
    logic [CYW-1:0] lg_cyc  [64];
    int             lg_n = 0;
    logic [AW-1:0]  dr_addr [64];
    int             dr_n = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Record requests and drops away from the active edge.
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            chk(req_cycle == cycle_in, "R8 issue stamp", req_cycle, cycle_in);
            if (lg_n < 64) begin
                lg_kind[lg_n] = req_kind;
                lg_addr[lg_n] = req_addr;
                lg_cyc[lg_n]  = cycle_in;
            end
            lg_n++;
        end
        if (rst_n && pf_drop) begin
            if (dr_n < 64) dr_addr[dr_n] = pf_drop_addr;
            dr_n++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        lg_n = 0;
        dr_n = 0;
    endtask

    task automatic push_st(input logic [AW-1:0] a, input logic c);
        st_push = 1; st_push_addr = a; st_push_cmt = c;
        step(1);
        st_push = 0;
    endtask

    task automatic push_ld(input logic [AW-1:0] a, input logic r);
        ld_push = 1; ld_push_addr = a; ld_push_rdy = r;
        step(1);
        ld_push = 0;
    endtask

    task automatic push_pf(input logic [AW-1:0] a, input logic r);
        pf_push = 1; pf_push_addr = a; pf_push_rdy = r;
        step(1);
        pf_push = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!req_valid && !pf_drop, "R1 no request after reset", req_valid, 0);
        chk(!st_full && !ld_full && !pf_full, "R1 queues not full", {st_full, ld_full, pf_full}, 0);
        step(0);
    endtask

    task automatic t_store_order();
        cache_rdy = 1;
        clear_log();
        push_st(32'hA000, 0);
        push_st(32'hB000, 1);
        step(10);
        chk(lg_n == 0, "R2 uncommitted head blocks", lg_n, 0);
        st_commit = 1;
        step(1);
        st_commit = 0;
        step(10);
        chk(lg_n == 2, "R2 both stores issued", lg_n, 2);
        chk(lg_addr[0] == 32'hA000, "R2 head first", lg_addr[0], 32'hA000);
        chk(lg_addr[1] == 32'hB000, "R2 second in order", lg_addr[1], 32'hB000);
        chk(lg_kind[0] == 2'b10, "R10 store kind", lg_kind[0], 2'b10);
    endtask

    task automatic t_cache_block();
        cache_rdy = 0;
        step(6);
        clear_log();
        push_st(32'hC000, 1);
        step(8);
        chk(lg_n == 0, "R3 no request while cache busy", lg_n, 0);
        cache_rdy = 1;
        step(8);
        chk(lg_n == 1 && lg_addr[0] == 32'hC000, "R3 issue after cache frees", lg_addr[0], 32'hC000);
    endtask

    task automatic t_load_skip();
        cache_rdy = 0;
        clear_log();
        push_ld(32'h0100, 0);
        push_ld(32'h0200, 1);
        step(6);
        cache_rdy = 1;
        step(10);
        chk(lg_n == 1, "R4 only ready load issued", lg_n, 1);
        chk(lg_addr[0] == 32'h0200, "R4 younger ready load bypasses", lg_addr[0], 32'h0200);
        chk(lg_kind[0] == 2'b01, "R10 load kind", lg_kind[0], 2'b01);
        wake_valid = 1; wake_addr = 32'h0100;
        step(1);
        wake_valid = 0;
        step(10);
        chk(lg_n == 2 && lg_addr[1] == 32'h0100, "R4 woken load issues", lg_addr[1], 32'h0100);
    endtask

    task automatic t_order_quantum();
        cache_rdy = 0;
        step(6);
        clear_log();
        for (int i = 0; i < 4; i++) push_st(32'h5000 + 32'(i) * 4, 1);
        push_ld(32'h6000, 1);
        push_pf(32'h1000, 1);
        step(4);
        cache_rdy = 1;
        step(16);
        chk(lg_n == 6, "R7 all six issued", lg_n, 6);
        chk(lg_kind[3] == 2'b10 && lg_kind[4] == 2'b01 && lg_kind[5] == 2'b11,
            "R7 stores then load then prefetch", {lg_kind[3], lg_kind[4], lg_kind[5]}, 6'b10_01_11);
        chk(lg_kind[5] == 2'b11, "R10 prefetch kind", lg_kind[5], 2'b11);
        chk(lg_cyc[1] - lg_cyc[0] == 1 && lg_cyc[2] - lg_cyc[1] == 1,
            "R7 back-to-back within round", lg_cyc[2] - lg_cyc[0], 2);
        chk(lg_cyc[3] - lg_cyc[2] == 2, "R7 idle cycle after quantum", lg_cyc[3] - lg_cyc[2], 2);
        chk(lg_cyc[4] - lg_cyc[3] == 2, "R7 load after empty store scan", lg_cyc[4] - lg_cyc[3], 2);
    endtask

    task automatic t_pf_filter();
        cache_rdy = 1;
        clear_log();
        push_pf(32'h1010, 1);
        step(10);
        chk(lg_n == 0, "R5 redundant prefetch no request", lg_n, 0);
        chk(dr_n == 1 && dr_addr[0] == 32'h1010, "R5 redundant prefetch dropped", dr_addr[0], 32'h1010);
        cache_rdy = 0;
        step(6);
        clear_log();
        push_st(32'h7000, 1);
        push_st(32'h7004, 1);
        push_pf(32'h1020, 1);
        push_pf(32'h2000, 1);
        cache_rdy = 1;
        step(16);
        chk(lg_n == 3 && dr_n == 1, "R5 drop plus three issues", lg_n, 3);
        chk(lg_addr[2] == 32'h2000, "R5 new prefetch issued", lg_addr[2], 32'h2000);
        chk(lg_cyc[2] - lg_cyc[1] == 4, "R5 drop uses no quantum", lg_cyc[2] - lg_cyc[1], 4);
    endtask

    task automatic pf_step(input logic [AW-1:0] a, input bit exp_issue);
        clear_log();
        push_pf(a, 1);
        step(10);
        chk(lg_n == (exp_issue ? 1 : 0), "R6 history issue decision", lg_n, exp_issue);
        chk(dr_n == (exp_issue ? 0 : 1), "R6 history drop decision", dr_n, !exp_issue);
    endtask

    task automatic t_hist_fifo();
        cache_rdy = 1;
        pf_step(32'h3000, 1);
        pf_step(32'h4000, 1);
        pf_step(32'h5000, 1);
        pf_step(32'h1000, 1);
        pf_step(32'h2000, 1);
        pf_step(32'h4008, 0);
    endtask

    task automatic t_full();
        cache_rdy = 0;
        step(6);
        clear_log();
        for (int i = 0; i < 9; i++) push_ld(32'h8000 + 32'(i) * 4, 1);
        @(negedge clk);
        chk(ld_full, "R9 full after eight pushes", ld_full, 1);
        step(0);
        cache_rdy = 1;
        step(40);
        chk(lg_n == 8, "R9 ninth push discarded", lg_n, 8);
        chk(lg_addr[7] == 32'h801C, "R9 last kept load", lg_addr[7], 32'h801C);
        chk(!ld_full, "R9 full clears", ld_full, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_store_order();
        t_cache_block();
        t_load_skip();
        t_order_quantum();
        t_pf_filter();
        t_hist_fifo();
        t_full();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule